// File: doc/BRIEF.md
# Edge or Level Interrupt Register

This block collects live condition flags from a packet receiver, such as the flag that marks the current packet as errored. It turns each flag into a sticky interrupt event that software can read and acknowledge. Each source is set to one of two detection kinds when the block is elaborated. A level source raises its event on every cycle its flag is high. An edge source raises its event only on a 0-to-1 change of its flag, so a flag that stays high produces one event. Because the flag drops for at least one cycle between packets, consecutive errored packets each produce a fresh event.

Software sees four 32-bit words through a single-cycle register port: a summary pending bit, the live flags, the per-source enable mask and the event bits. Event bits are acknowledged by writing ones to them. The same masked events are ORed onto one interrupt request pin. The port has no handshake. Every access completes in the cycle it is presented, so the block never applies back-pressure and the requester never needs to wait. Reads are combinational and writes land on the next rising clock edge.

Top module: `edge_level_irq_regs`

## Requirements
- R1: After the active-low reset, the enable bits, the event bits and the edge-history flops are all 0, every register reads 0 while all flags are low, and `irq_o` is 0.
- R2: The enable word at offset 0x8 can be written and read back in bits [NUM_SRC-1:0], and its upper bits read 0. Writes to offsets 0x0 and 0x4 change no state.
- R3: Offset 0x4 returns the live flags `status_i` in bits [NUM_SRC-1:0] in the same cycle, through the combinational read path.
- R4: A source whose enable bit is 0 never sets its event bit, whatever its flag does.
- R5: A source whose bit in `EDGE_MASK` is 1 (edge kind) sets its event only in a cycle where its flag is 1 and was 0 in the previous cycle. After the event is cleared, a flag that stays high raises no new event. A later 0-then-1 change raises a new event. With the default `EDGE_MASK` of 4'b0101, sources 0 and 2 are of edge kind.
- R6: A source whose bit in `EDGE_MASK` is 0 (level kind) sets its event in every cycle its flag is 1 while it is enabled. A clear written while the flag is still high therefore leaves the event set. With the default mask, sources 1 and 3 are of level kind.
- R7: Writing to offset 0xC clears each event bit whose data bit is 1. Data bits that are 0 leave their event bits unchanged.
- R8: A set event bit stays set until software clears it, even after its flag drops.
- R9: When a hardware set and a software clear reach the same event bit on the same clock edge, the bit ends up set.
- R10: Bit 0 of offset 0x0 and the output `irq_o` are both 1 exactly when some source has its event bit and its enable bit both at 1. Disabling a source hides its pending event without erasing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | NUM_SRC | Live condition flags, one per source |
| reg_addr | input | 4 | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe; the write lands on the next rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is a hardware set colliding with a software clear on the same event bit in the same cycle. The bench reaches it by raising an edge-kind flag on the same falling edge that presents the clearing write, so both reach the following rising edge together. A second awkward case is a clear issued while a level-kind flag is still held high. The bench keeps the flag asserted, shows that the clear does not stick, and then masks the source first to show that the clear does take effect.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_SUMMARY = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_ENABLE  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_EVENT   = 4'hC;

  typedef enum logic [2:0] {
    SEL_SUMMARY,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_EVENT,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/irq_trigger_gen.sv
module irq_trigger_gen #(
  parameter int unsigned NUM_SRC = 4,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [NUM_SRC-1:0] prev_o,
  output logic [NUM_SRC-1:0] trig_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= status_i[i];
      end
      assign prev_o[i] = prev_q;
      assign trig_o[i] = status_i[i] & ~prev_q;
    end else begin : g_level
      assign prev_o[i] = 1'b0;
      assign trig_o[i] = status_i[i];
    end
  end
endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] set_o,
  output logic [NUM_SRC-1:0] evt_o,
  output logic               pending_o
);
  logic [NUM_SRC-1:0] evt_q;

  assign set_o = trig_i & en_i;

  // hardware set takes priority over a software clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= set_o | (evt_q & ~clr_i);
  end

  assign evt_o     = evt_q;
  assign pending_o = |(evt_q & en_i);
endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_regs_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               pending_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [DATA_W-1:0]  reg_rdata
);
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] en_q;

  always_comb begin
    unique case (reg_addr)
      OFS_SUMMARY: sel = SEL_SUMMARY;
      OFS_STATUS:  sel = SEL_STATUS;
      OFS_ENABLE:  sel = SEL_ENABLE;
      OFS_EVENT:   sel = SEL_EVENT;
      default:     sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           en_q <= '0;
    else if (reg_wr && sel == SEL_ENABLE) en_q <= reg_wdata[NUM_SRC-1:0];
  end

  assign en_o  = en_q;
  assign clr_o = (reg_wr && sel == SEL_EVENT) ? reg_wdata[NUM_SRC-1:0] : '0;

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_SUMMARY: reg_rdata[0]         = pending_i;
      SEL_STATUS:  reg_rdata[NUM_SRC-1:0] = status_i;
      SEL_ENABLE:  reg_rdata[NUM_SRC-1:0] = en_q;
      SEL_EVENT:   reg_rdata[NUM_SRC-1:0] = evt_i;
      default:     reg_rdata = '0;
    endcase
  end

  if (NUM_SRC < DATA_W) begin : g_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = |reg_wdata[DATA_W-1:NUM_SRC];
  end
endmodule

// File: rtl/edge_level_irq_regs.sv
module edge_level_irq_regs
  import irq_regs_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = 4'b0101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] prev_vec;
  logic [NUM_SRC-1:0] trig_vec;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] evt_vec;
  logic               pending;

  irq_trigger_gen #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_trig (
    .clk(clk), .rst_n(rst_n), .status_i(status_i),
    .prev_o(prev_vec), .trig_o(trig_vec)
  );

  irq_event_bank #(.NUM_SRC(NUM_SRC)) u_evt (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_vec), .en_i(en_vec),
    .clr_i(clr_vec), .set_o(set_vec), .evt_o(evt_vec), .pending_o(pending)
  );

  irq_reg_if #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .status_i(status_i), .evt_i(evt_vec),
    .pending_i(pending), .en_o(en_vec), .clr_o(clr_vec), .reg_rdata(reg_rdata)
  );

  assign irq_o = pending;
endmodule

// File: rtl/irq_regs_checker.sv
module irq_regs_checker
  import irq_regs_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] status_i,
  input logic [NUM_SRC-1:0] prev_vec,
  input logic [NUM_SRC-1:0] set_vec,
  input logic [NUM_SRC-1:0] clr_vec,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [NUM_SRC-1:0] evt_vec,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_wr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               irq_o
);
  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_ENABLE) |=> en_vec == $past(reg_wdata[NUM_SRC-1:0]));

  a_r4_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_vec & ~$past(evt_vec)) & ~$past(en_vec)) == '0);

  a_r5_edge_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_vec & ~$past(evt_vec)) & EDGE_MASK & ~($past(status_i) & ~$past(prev_vec))) == '0);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_vec) & ~$past(clr_vec)) & ~evt_vec) == '0);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(set_vec) & ~evt_vec) == '0);

  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (evt_vec & en_vec) != '0);
endmodule

bind edge_level_irq_regs irq_regs_checker #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_i(status_i), .prev_vec(prev_vec),
  .set_vec(set_vec), .clr_vec(clr_vec), .en_vec(en_vec), .evt_vec(evt_vec),
  .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .irq_o(irq_o)
);

// File: tb/test_edge_level_irq_regs.sv
module test_edge_level_irq_regs;
  localparam int N = 4;
  localparam logic [3:0] A_SUM = 4'h0, A_STA = 4'h4, A_EN = 4'h8, A_EVT = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] status_i = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  edge_level_irq_regs i_edge_level_irq_regs (
    .clk(clk), .rst_n(rst_n), .status_i(status_i), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_SUM, v); check("R1 summary", v, 0);
    rd(A_STA, v); check("R1 status",  v, 0);
    rd(A_EN,  v); check("R1 enable",  v, 0);
    rd(A_EVT, v); check("R1 event",   v, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_enable_rw();
    logic [31:0] v;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v); check("R2 enable readback", v, 32'hF);
    wr(A_SUM, 32'h0); wr(A_STA, 32'h0);
    rd(A_EN, v); check("R2 read-only writes ignored", v, 32'hF);
    rd(A_EVT, v); check("R2 events untouched", v, 0);
    wr(A_EN, 32'h0);
    rd(A_EN, v); check("R2 enable cleared", v, 0);
  endtask

  task automatic t_masked_and_status();
    logic [31:0] v;
    @(negedge clk); status_i = 4'hF;
    cycles(3);
    rd(A_STA, v); check("R3 live status", v, 32'hF);
    rd(A_EVT, v); check("R4 masked no event", v, 0);
    check("R4 masked no irq", {31'b0, irq_o}, 0);
    status_i = 4'h5;
    #1; rd(A_STA, v); check("R3 status same cycle", v, 32'h5);
    @(negedge clk); status_i = '0;
    cycles(2);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(A_EN, 32'h1);
    status_i[0] = 1'b1;
    @(negedge clk);
    rd(A_EVT, v); check("R5 edge raises event", v, 32'h1);
    rd(A_SUM, v); check("R10 summary set", v, 32'h1);
    check("R10 irq set", {31'b0, irq_o}, 1);
    wr(A_EVT, 32'h1);
    cycles(3);
    rd(A_EVT, v); check("R5 held flag no retrigger", v, 0);
    check("R10 irq clear", {31'b0, irq_o}, 0);
    status_i[0] = 1'b0;
    @(negedge clk); status_i[0] = 1'b1;
    @(negedge clk);
    rd(A_EVT, v); check("R5 next packet new event", v, 32'h1);
    status_i[0] = 1'b0;
    cycles(3);
    rd(A_EVT, v); check("R8 sticky after flag drops", v, 32'h1);
    wr(A_EVT, 32'h0);
    rd(A_EVT, v); check("R7 write zero no effect", v, 32'h1);
    wr(A_EVT, 32'hFFFF_FFFE);
    rd(A_EVT, v); check("R7 zero bit keeps event", v, 32'h1);
    wr(A_EN, 32'h0);
    rd(A_SUM, v); check("R10 disabled hides summary", v, 0);
    check("R10 disabled hides irq", {31'b0, irq_o}, 0);
    rd(A_EVT, v); check("R10 event kept while disabled", v, 32'h1);
    wr(A_EVT, 32'h1);
    rd(A_EVT, v); check("R7 write one clears", v, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(A_EN, 32'h2);
    status_i[1] = 1'b1;
    @(negedge clk);
    rd(A_EVT, v); check("R6 level raises event", v, 32'h2);
    wr(A_EVT, 32'h2);
    rd(A_EVT, v); check("R6 clear while high does not stick", v, 32'h2);
    wr(A_EN, 32'h0);
    wr(A_EVT, 32'h2);
    rd(A_EVT, v); check("R6 clear after mask", v, 0);
    check("R4 masked level irq", {31'b0, irq_o}, 0);
    status_i[1] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    wr(A_EN, 32'h1);
    @(negedge clk);
    status_i[0] = 1'b1;
    reg_wr = 1'b1; reg_addr = A_EVT; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    rd(A_EVT, v); check("R9 set beats clear", v, 32'h1);
    status_i[0] = 1'b0;
    wr(A_EVT, 32'h1);
    rd(A_EVT, v); check("R9 later clear works", v, 0);
    wr(A_EN, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_rw();
    t_masked_and_status();
    t_edge();
    t_level();
    t_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule